// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel. It walks a linked list of descriptors held in memory and copies data from a source region to a target region. Each descriptor is four 32-bit words: next pointer, source address, target address and command. The command word holds the remaining byte count, the element width, the burst size, the address-increment enables, the flow-control enables and two event enables. Data moves in bursts. The channel reads every element of a burst into a local buffer, then writes them all out. After each burst it stores the reduced count back into its copy of the command word.

A start pulse launches the channel in one of two modes. In the fetching mode it loads the first descriptor from a pointer. In the direct mode it takes source, target and command from input ports and stops when that transfer ends. Flow-controlled descriptors pace each burst on a peripheral request line. When that line falls after a burst, an end-of-receive event is raised, and this event can stop the chain or make it jump to the next descriptor while bytes are still left. Four sticky event flags record start, end, end-of-receive and stop.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset the channel is idle: run_o=0, stopped_o=1, every event flag is 0 and mem_req_o=0.
- R2: A descriptor is loaded with four word reads (mem_size_o=2) at base, base+4, base+8 and base+12. The base is the pointer with its low 4 bits cleared. The words are taken in the order next pointer, source, target, command.
- R3: When bit 1 of the pointer is set and the compare status is 1, the descriptor base is the masked pointer plus 32.
- R4: Command bits 12:0 are the byte count. Bits 15:14 select the element width: code 1 is 1 byte (mem_size_o=0), code 2 is 2 bytes (1), code 3 is 4 bytes (2). Bits 17:16 select a burst of 4<<code bytes. Each burst moves min(count, burst) bytes and performs all of its element reads before its element writes. Elements sit in the low bits of the data buses.
- R5: Command bit 31 makes the source address advance by the element width after each element, and bit 30 does the same for the target address. When the bit is clear, that address stays fixed.
- R6: Command bit 29 (source) or bit 28 (target) enables flow control. The flagged address has its low 2 bits cleared when the descriptor is loaded. While either bit is set, each burst waits until req_i is high.
- R7: start_evt_o is set when a descriptor whose command bit 22 is set is loaded. end_evt_o is set when the count reaches zero and command bit 21 is set.
- R8: When the count reaches zero, the channel stops if direct mode is active, if bit 0 of the next pointer is set, or if the end-of-receive stop enable is set. Otherwise it loads the descriptor at the next pointer.
- R9: If flow control is enabled and req_i is low after a burst, eor_evt_o is set. With the end-of-receive stop enable the channel then stops, even with bytes left. Otherwise, with the jump enable in fetching mode, it loads the next descriptor.
- R10: In direct mode (nofetch_i=1 at start) the channel reads no descriptor. It uses ld_src_i, ld_dst_i and ld_cmd_i as loaded, and it stops when the count reaches zero.
- R11: start_i is ignored while the channel runs. An accepted start clears all event flags and drops stopped_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| desc_ptr_i | input | 32 | First descriptor pointer (fetching mode) |
| nofetch_i | input | 1 | Selects direct mode at start |
| eor_stop_en_i | input | 1 | End-of-receive stops the channel |
| eor_jump_en_i | input | 1 | End-of-receive jumps to the next descriptor |
| cmp_st_i | input | 1 | Compare status used for branching |
| ld_src_i | input | 32 | Source address for direct mode |
| ld_dst_i | input | 32 | Target address for direct mode |
| ld_cmd_i | input | 32 | Command word for direct mode |
| req_i | input | 1 | Peripheral request for flow control |
| mem_req_o | output | 1 | Memory access request, held until ack |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | 32 | Byte address |
| mem_size_o | output | 2 | log2 of the access width in bytes |
| mem_wdata_o | output | 32 | Write data, right-justified |
| mem_rdata_i | input | 32 | Read data, valid with ack on a read |
| mem_ack_i | input | 1 | Completes the current access |
| run_o | output | 1 | Channel active |
| stopped_o | output | 1 | Channel idle |
| start_evt_o | output | 1 | Sticky descriptor-start event |
| end_evt_o | output | 1 | Sticky transfer-end event |
| eor_evt_o | output | 1 | Sticky end-of-receive event |

## Verification
The bench aims at the following corner cases:
- A count that is not a multiple of the burst leaves a short final burst. Getting it wrong overruns or truncates the target.
- A pointer with stray low bits and the compare branch. A wrong base makes the channel fetch the wrong descriptor and write a region no one expected.
- Flow control stalls on a low request, realigns an unaligned source, and raises end-of-receive when the request falls in the middle of a transfer. A design that misorders the end-of-receive checks either keeps copying after a stop or misses the jump to the next descriptor.
- A start pulse given while the channel waits must not restart the chain; if it does, the channel fetches again and emits extra writes.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LEN_W  = 13;

  localparam int unsigned NXT_STOP   = 0;
  localparam int unsigned NXT_BRANCH = 1;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_WAIT, S_RD, S_WR, S_POST, S_ENDCHK
  } chan_state_e;

  typedef struct packed {
    logic             inc_src;
    logic             inc_dst;
    logic             flow_src;
    logic             flow_dst;
    logic             start_ev;
    logic             end_ev;
    logic [1:0]       bcode;
    logic [1:0]       wcode;
    logic [LEN_W-1:0] len;
  } cmd_t;

  function automatic cmd_t unpack_cmd(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.inc_src  = w[31];
    c.inc_dst  = w[30];
    c.flow_src = w[29];
    c.flow_dst = w[28];
    c.start_ev = w[22];
    c.end_ev   = w[21];
    c.bcode    = w[17:16];
    c.wcode    = w[15:14];
    c.len      = w[LEN_W-1:0];
    return c;
  endfunction

  // width code -> log2 bytes; code 0 falls back to bytes
  function automatic logic [1:0] width_log(input logic [1:0] code);
    case (code)
      2'd2:    return 2'd1;
      2'd3:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/dma_burst_calc.sv
module dma_burst_calc
  import dma_chan_pkg::*;
#(
  parameter int unsigned MAX_BURST = 32,
  localparam int unsigned CNT_W = $clog2(MAX_BURST) + 1
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [1:0]       wcode_i,
  input  logic [1:0]       bcode_i,
  output logic [1:0]       wlog_o,
  output logic [2:0]       wbytes_o,
  output logic [CNT_W-1:0] n_elem_o,
  output logic [LEN_W-1:0] len_next_o
);
  logic [LEN_W-1:0] burst_b, chunk;
  logic [CNT_W:0]   rounded;

  always_comb begin
    wlog_o     = width_log(wcode_i);
    wbytes_o   = 3'd1 << wlog_o;
    burst_b    = LEN_W'(4) << bcode_i;
    chunk      = (len_i < burst_b) ? len_i : burst_b;
    len_next_o = len_i - chunk;
    rounded    = {1'b0, chunk[CNT_W-1:0]} + (CNT_W+1)'(wbytes_o - 3'd1);
    n_elem_o   = CNT_W'(rounded >> wlog_o);
  end
endmodule

// File: rtl/dma_elem_buf.sv
module dma_elem_buf #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 32,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (we_i && (waddr_i == IW'(g))) slot[g] <= wdata_i;
    end
  end

  assign rdata_o = slot[raddr_i];
endmodule

// File: rtl/dma_desc_addr.sv
module dma_desc_addr
  import dma_chan_pkg::*;
(
  input  logic [WORD_W-1:0] ptr_i,
  input  logic              cmp_i,
  output logic [WORD_W-1:0] base_o
);
  logic [WORD_W-1:0] aligned;
  assign aligned = {ptr_i[WORD_W-1:4], 4'h0};
  assign base_o  = aligned + ((ptr_i[NXT_BRANCH] && cmp_i) ? WORD_W'(32) : WORD_W'(0));
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dma_chan_pkg::*;
#(
  parameter int unsigned MAX_BURST = 32,
  localparam int unsigned CNT_W = $clog2(MAX_BURST) + 1,
  localparam int unsigned IW    = $clog2(MAX_BURST)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] desc_ptr_i,
  input  logic              nofetch_i,
  input  logic              eor_stop_en_i,
  input  logic              eor_jump_en_i,
  input  logic              cmp_st_i,
  input  logic [WORD_W-1:0] ld_src_i,
  input  logic [WORD_W-1:0] ld_dst_i,
  input  logic [WORD_W-1:0] ld_cmd_i,
  input  logic              req_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              run_o,
  output logic              stopped_o,
  output logic              start_evt_o,
  output logic              end_evt_o,
  output logic              eor_evt_o
);
  chan_state_e       state_q;
  logic [WORD_W-1:0] next_q, src_q, dst_q, fbase_q;
  cmd_t              cmd_q, rd_cmd;
  logic [1:0]        fbeat_q;
  logic [CNT_W-1:0]  idx_q, n_elem_q;
  logic              nofetch_q, eor_stop_q, eor_jump_q, cmp_q;
  logic              start_evt_q, end_evt_q, eor_evt_q;

  logic [1:0]        wlog;
  logic [2:0]        wbytes;
  logic [CNT_W-1:0]  n_elem;
  logic [LEN_W-1:0]  len_next;
  logic [WORD_W-1:0] ptr_sel, desc_base, buf_rdata, rd_masked, src_step, dst_step;
  logic              cmp_sel, flow, req_block, last_elem;

  dma_burst_calc #(.MAX_BURST(MAX_BURST)) u_calc (
    .len_i(cmd_q.len), .wcode_i(cmd_q.wcode), .bcode_i(cmd_q.bcode),
    .wlog_o(wlog), .wbytes_o(wbytes), .n_elem_o(n_elem), .len_next_o(len_next)
  );

  assign ptr_sel = (state_q == S_IDLE) ? desc_ptr_i : next_q;
  assign cmp_sel = (state_q == S_IDLE) ? cmp_st_i : cmp_q;

  dma_desc_addr u_daddr (.ptr_i(ptr_sel), .cmp_i(cmp_sel), .base_o(desc_base));

  always_comb begin
    case (wlog)
      2'd0:    rd_masked = {24'h0, mem_rdata_i[7:0]};
      2'd1:    rd_masked = {16'h0, mem_rdata_i[15:0]};
      default: rd_masked = mem_rdata_i;
    endcase
  end

  dma_elem_buf #(.DEPTH(MAX_BURST), .W(WORD_W)) u_buf (
    .clk_i(clk_i), .we_i(state_q == S_RD && mem_ack_i), .waddr_i(idx_q[IW-1:0]),
    .wdata_i(rd_masked), .raddr_i(idx_q[IW-1:0]), .rdata_o(buf_rdata)
  );

  assign rd_cmd    = unpack_cmd(mem_rdata_i);
  assign flow      = cmd_q.flow_src | cmd_q.flow_dst;
  assign req_block = flow && !req_i;
  assign last_elem = (idx_q == n_elem_q - CNT_W'(1));
  assign src_step  = cmd_q.inc_src ? WORD_W'(wbytes) : '0;
  assign dst_step  = cmd_q.inc_dst ? WORD_W'(wbytes) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      next_q      <= '0;
      src_q       <= '0;
      dst_q       <= '0;
      fbase_q     <= '0;
      cmd_q       <= '0;
      fbeat_q     <= '0;
      idx_q       <= '0;
      n_elem_q    <= '0;
      nofetch_q   <= 1'b0;
      eor_stop_q  <= 1'b0;
      eor_jump_q  <= 1'b0;
      cmp_q       <= 1'b0;
      start_evt_q <= 1'b0;
      end_evt_q   <= 1'b0;
      eor_evt_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          nofetch_q   <= nofetch_i;
          eor_stop_q  <= eor_stop_en_i;
          eor_jump_q  <= eor_jump_en_i;
          cmp_q       <= cmp_st_i;
          start_evt_q <= 1'b0;
          end_evt_q   <= 1'b0;
          eor_evt_q   <= 1'b0;
          next_q      <= desc_ptr_i;
          if (nofetch_i) begin
            src_q   <= ld_src_i;
            dst_q   <= ld_dst_i;
            cmd_q   <= unpack_cmd(ld_cmd_i);
            state_q <= S_WAIT;
          end else begin
            fbase_q <= desc_base;
            fbeat_q <= '0;
            state_q <= S_FETCH;
          end
        end
        S_FETCH: if (mem_ack_i) begin
          fbeat_q <= fbeat_q + 2'd1;
          case (fbeat_q)
            2'd0: next_q <= mem_rdata_i;
            2'd1: src_q  <= mem_rdata_i;
            2'd2: dst_q  <= mem_rdata_i;
            default: begin
              cmd_q <= rd_cmd;
              if (rd_cmd.flow_src) src_q <= {src_q[WORD_W-1:2], 2'b00};
              if (rd_cmd.flow_dst) dst_q <= {dst_q[WORD_W-1:2], 2'b00};
              if (rd_cmd.start_ev) start_evt_q <= 1'b1;
              state_q <= S_WAIT;
            end
          endcase
        end
        S_WAIT: begin
          if (cmd_q.len == '0) state_q <= S_ENDCHK;
          else if (!req_block) begin
            cmd_q.len <= len_next;
            n_elem_q  <= n_elem;
            idx_q     <= '0;
            state_q   <= S_RD;
          end
        end
        S_RD: if (mem_ack_i) begin
          src_q <= src_q + src_step;
          if (last_elem) begin
            idx_q   <= '0;
            state_q <= S_WR;
          end else idx_q <= idx_q + CNT_W'(1);
        end
        S_WR: if (mem_ack_i) begin
          dst_q <= dst_q + dst_step;
          if (last_elem) state_q <= S_POST;
          else idx_q <= idx_q + CNT_W'(1);
        end
        S_POST: begin
          state_q <= S_ENDCHK;
          if (req_block) begin
            eor_evt_q <= 1'b1;
            if (eor_stop_q) state_q <= S_IDLE;
            else if (eor_jump_q && !nofetch_q) begin
              fbase_q <= desc_base;
              fbeat_q <= '0;
              state_q <= S_FETCH;
            end
          end
        end
        S_ENDCHK: begin
          if (cmd_q.len != '0) state_q <= S_WAIT;
          else begin
            if (cmd_q.end_ev) end_evt_q <= 1'b1;
            if (nofetch_q || next_q[NXT_STOP] || eor_stop_q) state_q <= S_IDLE;
            else begin
              fbase_q <= desc_base;
              fbeat_q <= '0;
              state_q <= S_FETCH;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = (state_q == S_FETCH) || (state_q == S_RD) || (state_q == S_WR);
    mem_we_o    = (state_q == S_WR);
    mem_size_o  = (state_q == S_FETCH) ? 2'd2 : wlog;
    mem_wdata_o = (state_q == S_WR) ? buf_rdata : '0;
    case (state_q)
      S_FETCH: mem_addr_o = fbase_q + {28'h0, fbeat_q, 2'b00};
      S_RD:    mem_addr_o = src_q;
      S_WR:    mem_addr_o = dst_q;
      default: mem_addr_o = '0;
    endcase
  end

  assign run_o       = (state_q != S_IDLE);
  assign stopped_o   = (state_q == S_IDLE);
  assign start_evt_o = start_evt_q;
  assign end_evt_o   = end_evt_q;
  assign eor_evt_o   = eor_evt_q;

  // R2: an access holds its address until acknowledged
  a_r2_hold_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R4: the count is updated only between bursts
  a_r4_len_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RD && $past(state_q) == S_RD) |-> $stable(cmd_q.len));

  // R5: a fixed source stays put across element reads
  a_r5_fixed_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RD && mem_ack_i && !cmd_q.inc_src) |=> $stable(src_q));

  // R6: a flow-controlled burst does not start without a request
  a_r6_wait_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && cmd_q.len != '0 && flow && !req_i) |=> (state_q == S_WAIT));

  // R7: the end event rises only with an exhausted count
  a_r7_end_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(end_evt_o) |-> (cmd_q.len == '0));

  // R9: end-of-receive rises only under flow control
  a_r9_eor_flow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eor_evt_o) |-> (cmd_q.flow_src || cmd_q.flow_dst));
endmodule

// File: tb/dma_chain_chan_bench.sv
module dma_chain_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] desc_ptr_i = '0;
  logic        nofetch_i = 1'b0, eor_stop_en_i = 1'b0, eor_jump_en_i = 1'b0, cmp_st_i = 1'b0;
  logic [31:0] ld_src_i = '0, ld_dst_i = '0, ld_cmd_i = '0;
  logic        req_i = 1'b0;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [1:0]  mem_size_o;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_ack_i = 1'b0;
  logic        run_o, stopped_o, start_evt_o, end_evt_o, eor_evt_o;

  int total = 0, bad = 0, wr_cnt = 0;
  logic [7:0]  mem [4096];
  logic [65:0] exp_q [$];
  logic [31:0] rd_log [$];

  always #10 clk = ~clk;

  dma_chain_chan u_dma_chain_chan (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .desc_ptr_i(desc_ptr_i),
    .nofetch_i(nofetch_i), .eor_stop_en_i(eor_stop_en_i), .eor_jump_en_i(eor_jump_en_i),
    .cmp_st_i(cmp_st_i), .ld_src_i(ld_src_i), .ld_dst_i(ld_dst_i), .ld_cmd_i(ld_cmd_i),
    .req_i(req_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_size_o(mem_size_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .mem_ack_i(mem_ack_i), .run_o(run_o), .stopped_o(stopped_o),
    .start_evt_o(start_evt_o), .end_evt_o(end_evt_o), .eor_evt_o(eor_evt_o)
  );

  function automatic logic [31:0] rd_bytes(input logic [31:0] a, input int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v[8*i +: 8] = mem[(a + 32'(i)) & 32'hFFF];
    return v;
  endfunction

  // memory slave: one access per two cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_ack_i <= 1'b0;
    else if (mem_req_o && !mem_ack_i) begin
      mem_ack_i <= 1'b1;
      if (mem_we_o) begin
        for (int i = 0; i < (1 << mem_size_o); i++)
          mem[(mem_addr_o + 32'(i)) & 32'hFFF] = mem_wdata_o[8*i +: 8];
      end else mem_rdata_i <= rd_bytes(mem_addr_o, 4);
    end else mem_ack_i <= 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mem_req_o && !mem_ack_i) begin
      if (!mem_we_o) rd_log.push_back(mem_addr_o);
      else begin
        logic [65:0] e;
        logic [31:0] m;
        wr_cnt++;
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected write", mem_addr_o, 32'h0);
        else begin
          e = exp_q.pop_front();
          m = (mem_size_o == 2'd2) ? 32'hFFFF_FFFF : (mem_size_o == 2'd1) ? 32'hFFFF : 32'hFF;
          chk(mem_addr_o == e[65:34], "R4 write address", mem_addr_o, e[65:34]);
          chk(mem_size_o == e[33:32], "R4 write size", 32'(mem_size_o), 32'(e[33:32]));
          chk((mem_wdata_o & m) == e[31:0], "R5 write data", mem_wdata_o & m, e[31:0]);
        end
      end
    end
  end

  task automatic put_word(input logic [31:0] a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[(a + 32'(i)) & 32'hFFF] = v[8*i +: 8];
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] nx, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] c);
    put_word(a, nx); put_word(a + 4, s); put_word(a + 8, d); put_word(a + 12, c);
  endtask

  // driver: expected write stream from a command word
  task automatic push_stream(input logic [31:0] s0, input logic [31:0] d0, input logic [31:0] c,
                             input int maxb);
    int len = int'(c[12:0]);
    int wl = (c[15:14] == 2'd3) ? 2 : (c[15:14] == 2'd2) ? 1 : 0;
    int w = 1 << wl;
    int b = 4 << c[17:16];
    int nb = 0;
    logic [31:0] s = c[29] ? {s0[31:2], 2'b00} : s0;
    logic [31:0] d = c[28] ? {d0[31:2], 2'b00} : d0;
    while (len > 0 && (maxb < 0 || nb < maxb)) begin
      int ch = (len < b) ? len : b;
      int n = (ch + w - 1) / w;
      for (int i = 0; i < n; i++) begin
        exp_q.push_back({d, 2'(wl), rd_bytes(s, w)});
        if (c[31]) s += 32'(w);
        if (c[30]) d += 32'(w);
      end
      len -= ch;
      nb++;
    end
  endtask

  task automatic kick(input logic [31:0] ptr);
    @(negedge clk);
    rd_log.delete();
    wr_cnt = 0;
    desc_ptr_i = ptr;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_stop();
    while (!stopped_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=stopped");
    finish_run();
  end

  localparam logic [31:0] INC2 = 32'hC000_0000;
  localparam logic [31:0] W1 = 32'h1 << 14, W2 = 32'h2 << 14, W4 = 32'h3 << 14;
  localparam logic [31:0] B8 = 32'h1 << 16, B16 = 32'h2 << 16;
  localparam logic [31:0] FSRC = 32'h1 << 29, FDST = 32'h1 << 28;
  localparam logic [31:0] SEV = 32'h1 << 22, EEV = 32'h1 << 21;

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = (i >= 32'h800) ? 8'h00 : 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!run_o && stopped_o, "R1 idle after reset", {30'h0, run_o, stopped_o}, 32'h1);
    chk(!start_evt_o && !end_evt_o && !eor_evt_o, "R1 events clear",
        {29'h0, start_evt_o, end_evt_o, eor_evt_o}, 32'h0);
    chk(!mem_req_o, "R1 no memory request", 32'(mem_req_o), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // single descriptor, unaligned pointer, word elements
    put_desc(32'h100, 32'h1, 32'h400, 32'h800, INC2 | SEV | EEV | W4 | B8 | 32'd24);
    push_stream(32'h400, 32'h800, INC2 | SEV | EEV | W4 | B8 | 32'd24, -1);
    kick(32'h105);
    wait_stop();
    chk(rd_log.size() == 10, "R4 read beats", 32'(rd_log.size()), 32'd10);
    for (int i = 0; i < 4; i++)
      chk(rd_log[i] == 32'h100 + 32'(4 * i), "R2 descriptor read address", rd_log[i], 32'h100 + 32'(4 * i));
    chk(exp_q.size() == 0, "R4 all writes seen", 32'(exp_q.size()), 32'h0);
    chk(start_evt_o && end_evt_o && !eor_evt_o, "R7 start and end events",
        {29'h0, start_evt_o, end_evt_o, eor_evt_o}, 32'h6);
    chk(!run_o && stopped_o, "R8 stop bit ends chain", 32'(run_o), 32'h0);

    // chain of two, short final burst, fixed source in second
    put_desc(32'h140, 32'h180, 32'h410, 32'h840, INC2 | W1 | 32'd10);
    put_desc(32'h180, 32'h1, 32'h430, 32'h880, 32'h4000_0000 | W2 | B16 | EEV | 32'd6);
    push_stream(32'h410, 32'h840, INC2 | W1 | 32'd10, -1);
    push_stream(32'h430, 32'h880, 32'h4000_0000 | W2 | B16 | EEV | 32'd6, -1);
    kick(32'h140);
    @(negedge clk);
    chk(!start_evt_o && !stopped_o, "R11 start clears events", {30'h0, start_evt_o, stopped_o}, 32'h0);
    wait_stop();
    chk(rd_log[14] == 32'h180, "R8 next descriptor fetched", rd_log[14], 32'h180);
    for (int i = 18; i < 21; i++)
      chk(rd_log[i] == 32'h430, "R5 fixed source address", rd_log[i], 32'h430);
    chk(exp_q.size() == 0 && end_evt_o, "R4 chain complete", 32'(exp_q.size()), 32'h0);

    // compare branch
    cmp_st_i = 1'b1;
    put_desc(32'h1C0, 32'h202, 32'h450, 32'h8C0, INC2 | W4 | 32'd4);
    put_desc(32'h200, 32'h1, 32'h460, 32'h900, INC2 | W4 | 32'd4);
    put_desc(32'h220, 32'h1, 32'h470, 32'h940, INC2 | W4 | B8 | 32'd8);
    push_stream(32'h450, 32'h8C0, INC2 | W4 | 32'd4, -1);
    push_stream(32'h470, 32'h940, INC2 | W4 | B8 | 32'd8, -1);
    kick(32'h1C0);
    wait_stop();
    cmp_st_i = 1'b0;
    chk(rd_log[5] == 32'h220, "R3 branch adds 32", rd_log[5], 32'h220);
    chk(exp_q.size() == 0, "R3 branch writes", 32'(exp_q.size()), 32'h0);

    // flow control stall, alignment, ignored start
    req_i = 1'b0;
    put_desc(32'h240, 32'h1, 32'h481, 32'h980, FSRC | INC2 | W4 | 32'd8);
    push_stream(32'h481, 32'h980, FSRC | INC2 | W4 | 32'd8, -1);
    kick(32'h240);
    repeat (40) @(negedge clk);
    chk(wr_cnt == 0 && run_o, "R6 burst waits for request", 32'(wr_cnt), 32'h0);
    desc_ptr_i = 32'h100;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    req_i = 1'b1;
    wait_stop();
    req_i = 1'b0;
    chk(rd_log[4] == 32'h480, "R6 source aligned", rd_log[4], 32'h480);
    chk(exp_q.size() == 0 && wr_cnt == 2, "R11 start ignored while running", 32'(wr_cnt), 32'h2);
    chk(!eor_evt_o, "R9 no eor with request held", 32'(eor_evt_o), 32'h0);

    // end-of-receive stop mid transfer
    eor_stop_en_i = 1'b1;
    put_desc(32'h280, 32'h2C0, 32'h490, 32'h9C0, FDST | INC2 | W4 | B8 | 32'd16);
    push_stream(32'h490, 32'h9C0, FDST | INC2 | W4 | B8 | 32'd16, 1);
    req_i = 1'b1;
    kick(32'h280);
    while (wr_cnt < 1) @(negedge clk);
    req_i = 1'b0;
    wait_stop();
    eor_stop_en_i = 1'b0;
    chk(eor_evt_o && !end_evt_o, "R9 eor event and no end", {30'h0, eor_evt_o, end_evt_o}, 32'h2);
    chk(wr_cnt == 2 && exp_q.size() == 0, "R9 eor stop halts transfer", 32'(wr_cnt), 32'h2);

    // end-of-receive jump
    eor_jump_en_i = 1'b1;
    put_desc(32'h2C0, 32'h300, 32'h4A0, 32'hA00, FSRC | INC2 | W4 | B8 | 32'd24);
    put_desc(32'h300, 32'h1, 32'h4C0, 32'hA40, INC2 | W2 | B8 | EEV | 32'd4);
    push_stream(32'h4A0, 32'hA00, FSRC | INC2 | W4 | B8 | 32'd24, 1);
    push_stream(32'h4C0, 32'hA40, INC2 | W2 | B8 | EEV | 32'd4, -1);
    req_i = 1'b1;
    kick(32'h2C0);
    while (wr_cnt < 1) @(negedge clk);
    req_i = 1'b0;
    wait_stop();
    eor_jump_en_i = 1'b0;
    chk(eor_evt_o && end_evt_o, "R9 eor jump reaches next descriptor", {30'h0, eor_evt_o, end_evt_o}, 32'h3);
    chk(wr_cnt == 4 && exp_q.size() == 0, "R9 jump write count", 32'(wr_cnt), 32'h4);

    // direct mode
    nofetch_i = 1'b1;
    ld_src_i = 32'h4D0;
    ld_dst_i = 32'hA80;
    ld_cmd_i = INC2 | W2 | B16 | 32'd8;
    push_stream(32'h4D0, 32'hA80, INC2 | W2 | B16 | 32'd8, -1);
    kick(32'h340);
    wait_stop();
    nofetch_i = 1'b0;
    chk(rd_log.size() == 4 && rd_log[0] == 32'h4D0, "R10 no descriptor read", rd_log[0], 32'h4D0);
    chk(exp_q.size() == 0 && stopped_o, "R10 direct transfer stops", 32'(exp_q.size()), 32'h0);

    finish_run();
  end
endmodule